// File: doc/BRIEF.md
# Key-Protected Watchdog Register Front End

This block is the register front end of a watchdog timer. It holds three registers: an 8-bit count register, an 8-bit control register, and a reset-control register. The reset-control register carries an overflow flag, a reset-enable bit and a reset-select bit. The timer core reads their contents from dedicated outputs, and it reports an overflow through an event input. The counting logic, the prescaler and the reset pulse logic are not part of this block.

Stray software writes cannot corrupt the registers. A write is accepted only when it is a word access whose upper byte holds one of two key codes. The key also chooses the destination of the lower byte. Reads are byte accesses, and their offsets differ from the write offsets. Any write that is not accepted raises a one-cycle reject pulse.

Top module: `wdt_regfile`

## Requirements
- R1: While reset is held and on release: count, control, overflow flag, reset-enable and reset-select are 0, `wr_reject` is 0 and `bus_rdata` is 0xFF.
- R2: A word write (`bus_word`=1) at offset 0 whose upper byte is 0x5A loads the lower byte into the count register. The control register is unchanged.
- R3: A word write at offset 0 whose upper byte is 0xA5 loads the lower byte into the control register. The count register is unchanged.
- R4: A byte write (`bus_word`=0) changes no register at any offset, whatever its data, and pulses `wr_reject`.
- R5: A word write at offset 2 with data 0xA500 clears the overflow flag and leaves reset-enable and reset-select unchanged.
- R6: A word write at offset 2 whose upper byte is 0x5A copies lower-byte bit 6 into reset-enable and bit 5 into reset-select. The overflow flag is unchanged.
- R7: The following writes change no register and make `wr_reject` high for exactly the one cycle after the write edge:
  - a word write whose upper byte is neither key;
  - a word write at offset 1 or 3;
  - a word write at offset 2 with upper byte 0xA5 and a nonzero lower byte.
- R8: `ovf_evt` high at a clock edge sets the overflow flag. When an event and a clear happen at the same edge, the flag ends up set.
- R9: A byte read loads `bus_rdata` at the edge that samples `bus_rd`. The value depends on the offset:
  - offset 0 returns the control register;
  - offset 1 returns the count register;
  - offset 3 returns {overflow, reset-enable, reset-select, 5'b11111}.
- R10: A read at offset 2, or any word read, returns 0xFF and changes no register.
- R11: A write takes effect at the edge that samples `bus_wr`. A read strobed in the very next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off | input | 2 | Register offset |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data: key in the upper byte, payload in the lower byte |
| bus_rdata | output | 8 | Registered read data |
| ovf_evt | input | 1 | Overflow event from the timer core |
| cnt_q | output | 8 | Count register contents |
| ctl_q | output | 8 | Control register contents |
| ovf_flag | output | 1 | Overflow flag |
| rst_en | output | 1 | Reset-enable bit |
| rst_sel | output | 1 | Reset-select bit |
| wr_reject | output | 1 | One-cycle pulse after a write that was not accepted |

## Verification
The bench covers the following corner cases:
- Byte writes carrying a valid key. A design that checks only the key would let these through and corrupt the count.
- The clear-overflow key with a nonzero payload. A design that ignores the lower byte would wrongly clear the flag.
- Word writes to the read-only offsets 1 and 3.
- An overflow event in the same cycle as a clear. A design with the wrong priority would lose the overflow.
- Reads at the unused offset and word-sized reads. These must return 0xFF and leave the state intact.
- Back-to-back write and read. A design that delays the register update by an extra cycle would return stale data.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OFF_W  = 2;
    localparam int PAD_W  = 5;

    localparam logic [BYTE_W-1:0] KEY_LOW_SEL  = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_HIGH_SEL = 8'hA5;
    localparam logic [BYTE_W-1:0] IDLE_READ    = 8'hFF;

    localparam logic [OFF_W-1:0] OFF_TIMER = 2'd0;
    localparam logic [OFF_W-1:0] OFF_CNT_R = 2'd1;
    localparam logic [OFF_W-1:0] OFF_RST_W = 2'd2;
    localparam logic [OFF_W-1:0] OFF_RST_R = 2'd3;

    typedef struct packed {
        logic              ld_cnt;
        logic              ld_ctl;
        logic              clr_ovf;
        logic              ld_rst;
        logic              reject;
    } wr_act_t;

    typedef struct packed {
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] ctl;
        logic              ovf;
        logic              en;
        logic              sel;
        logic [BYTE_W-1:0] rdata;
        logic              rej;
    } regs_t;
endpackage

// File: rtl/wdt_wr_decode.sv
module wdt_wr_decode
    import wdt_pkg::*;
(
    input  logic              wr,
    input  logic              word,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wdata,
    output wr_act_t           act
);
    logic [BYTE_W-1:0] key;
    logic [BYTE_W-1:0] pay;
    logic              key_lo;
    logic              key_hi;

    assign key    = wdata[WORD_W-1:BYTE_W];
    assign pay    = wdata[BYTE_W-1:0];
    assign key_lo = (key == KEY_LOW_SEL);
    assign key_hi = (key == KEY_HIGH_SEL);

    always_comb begin
        act = '0;
        if (wr) begin
            if (word && off == OFF_TIMER && key_lo) begin
                act.ld_cnt = 1'b1;
            end else if (word && off == OFF_TIMER && key_hi) begin
                act.ld_ctl = 1'b1;
            end else if (word && off == OFF_RST_W && key_lo) begin
                act.ld_rst = 1'b1;
            end else if (word && off == OFF_RST_W && key_hi && pay == '0) begin
                act.clr_ovf = 1'b1;
            end else begin
                act.reject = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_rd_select.sv
module wdt_rd_select
    import wdt_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic              word,
    input  logic [BYTE_W-1:0] cnt,
    input  logic [BYTE_W-1:0] ctl,
    input  logic              ovf,
    input  logic              en,
    input  logic              sel,
    output logic [BYTE_W-1:0] value
);
    always_comb begin
        value = IDLE_READ;
        if (!word) begin
            unique case (off)
                OFF_TIMER: value = ctl;
                OFF_CNT_R: value = cnt;
                OFF_RST_R: value = {ovf, en, sel, {PAD_W{1'b1}}};
                default:   value = IDLE_READ;
            endcase
        end
    end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic              bus_word,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ovf_evt,
    output logic [BYTE_W-1:0] cnt_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              ovf_flag,
    output logic              rst_en,
    output logic              rst_sel,
    output logic              wr_reject
);
    localparam regs_t RESET_VAL = '{cnt: '0, ctl: '0, ovf: 1'b0, en: 1'b0,
                                    sel: 1'b0, rdata: IDLE_READ, rej: 1'b0};

    regs_t             r_q;
    regs_t             r_d;
    wr_act_t           act;
    logic [BYTE_W-1:0] rd_val;

    wdt_wr_decode u_dec (
        .wr    (bus_wr),
        .word  (bus_word),
        .off   (bus_off),
        .wdata (bus_wdata),
        .act   (act)
    );

    wdt_rd_select u_rd (
        .off   (bus_off),
        .word  (bus_word),
        .cnt   (r_q.cnt),
        .ctl   (r_q.ctl),
        .ovf   (r_q.ovf),
        .en    (r_q.en),
        .sel   (r_q.sel),
        .value (rd_val)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rej = act.reject;
        if (act.ld_cnt) r_d.cnt = bus_wdata[BYTE_W-1:0];
        if (act.ld_ctl) r_d.ctl = bus_wdata[BYTE_W-1:0];
        if (act.ld_rst) begin
            r_d.en  = bus_wdata[6];
            r_d.sel = bus_wdata[5];
        end
        // A set from the core takes priority over a software clear.
        if (ovf_evt)           r_d.ovf = 1'b1;
        else if (act.clr_ovf)  r_d.ovf = 1'b0;
        if (bus_rd)            r_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign cnt_q     = r_q.cnt;
    assign ctl_q     = r_q.ctl;
    assign ovf_flag  = r_q.ovf;
    assign rst_en    = r_q.en;
    assign rst_sel   = r_q.sel;
    assign wr_reject = r_q.rej;
endmodule

// File: rtl/wdt_regfile_chk.sv
module wdt_regfile_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  bus_off,
    input logic              bus_word,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              ovf_evt,
    input logic [BYTE_W-1:0] cnt_q,
    input logic [BYTE_W-1:0] ctl_q,
    input logic              ovf_flag,
    input logic              rst_en,
    input logic              rst_sel,
    input logic              wr_reject
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && ctl_q == '0 && !ovf_flag && !rst_en && !rst_sel && !wr_reject)); // R1

    AST_CNT_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word && bus_off == OFF_TIMER && bus_wdata[15:8] == KEY_LOW_SEL)
        |=> (cnt_q == $past(bus_wdata[7:0]) && $stable(ctl_q))); // R2

    AST_CTL_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word && bus_off == OFF_TIMER && bus_wdata[15:8] == KEY_HIGH_SEL)
        |=> (ctl_q == $past(bus_wdata[7:0]) && $stable(cnt_q))); // R3

    AST_BYTE_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word)
        |=> ($stable(cnt_q) && $stable(ctl_q) && $stable(rst_en) && $stable(rst_sel) && wr_reject)); // R4

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word && bus_off == OFF_RST_W && bus_wdata == 16'hA500 && !ovf_evt)
        |=> (!ovf_flag && $stable(rst_en) && $stable(rst_sel))); // R5

    AST_RST_BITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word && bus_off == OFF_RST_W && bus_wdata[15:8] == KEY_LOW_SEL)
        |=> (rst_en == $past(bus_wdata[6]) && rst_sel == $past(bus_wdata[5]))); // R6

    AST_REJECT_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(bus_wr)); // R7

    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag); // R8

    AST_READ_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !ovf_evt)
        |=> ($stable(cnt_q) && $stable(ctl_q) && $stable(ovf_flag) && $stable(rst_en) && $stable(rst_sel))); // R10

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_word || bus_off == OFF_RST_W)) |=> (bus_rdata == IDLE_READ)); // R10
endmodule

bind wdt_regfile wdt_regfile_chk u_chk (.*);

// File: tb/sim_wdt_regfile.sv
module sim_wdt_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_off = '0;
    logic        bus_word = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ovf_evt = 1'b0;
    logic [7:0]  cnt_q;
    logic [7:0]  ctl_q;
    logic        ovf_flag;
    logic        rst_en;
    logic        rst_sel;
    logic        wr_reject;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wdt_regfile u0 (.*);

    // Vector: {wr_off[2], wr_word[1], wr_data[16], rd_off[2], exp_rd[8], exp_rej[1], req[4]}
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 1'b1, 16'h5A3C, 2'd1, 8'h3C, 1'b0, 4'd2},  // R2 count load
        {2'd0, 1'b1, 16'hA517, 2'd0, 8'h17, 1'b0, 4'd3},  // R3 control load
        {2'd0, 1'b0, 16'h5A99, 2'd1, 8'h3C, 1'b1, 4'd4},  // R4 byte write ignored
        {2'd0, 1'b1, 16'h1299, 2'd0, 8'h17, 1'b1, 4'd7},  // R7 bad key
        {2'd2, 1'b1, 16'h5A60, 2'd3, 8'h7F, 1'b0, 4'd6},  // R6 en=1 sel=1, R9 pad ones
        {2'd2, 1'b1, 16'hA501, 2'd3, 8'h7F, 1'b1, 4'd7},  // R7 clear key, nonzero payload
        {2'd2, 1'b1, 16'h5A20, 2'd3, 8'h3F, 1'b0, 4'd6},  // R6 en=0 sel=1
        {2'd2, 1'b1, 16'hA500, 2'd3, 8'h3F, 1'b0, 4'd5},  // R5 clear keeps en/sel
        {2'd1, 1'b1, 16'h5A55, 2'd1, 8'h3C, 1'b1, 4'd7},  // R7 write to read-only offset
        {2'd0, 1'b1, 16'h5AFF, 2'd1, 8'hFF, 1'b0, 4'd2},  // R2 all ones
        {2'd2, 1'b0, 16'h5A40, 2'd3, 8'h3F, 1'b1, 4'd4},  // R4 byte write at reset-control
        {2'd0, 1'b1, 16'hA500, 2'd0, 8'h00, 1'b0, 4'd3}   // R3 back to zero, R9 offset 0
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] off, input logic word, input logic [15:0] data,
                            input logic evt);
        @(negedge clk);
        bus_off = off; bus_word = word; bus_wdata = data; bus_wr = 1'b1; ovf_evt = evt;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; ovf_evt = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] off, input logic word);
        bus_off = off; bus_word = word; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1 cnt", cnt_q, 8'h00);
        check8("R1 ctl", ctl_q, 8'h00);
        check8("R1 flags", {5'b0, ovf_flag, rst_en, rst_sel}, 8'h00);
        check8("R1 rdata", bus_rdata, 8'hFF);
        check8("R1 reject", {7'b0, wr_reject}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(2'd3, 1'b0);
        check8("R1 R9 reset-control read", bus_rdata, 8'h1F);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            do_write(v[33:32], v[31], v[30:15], 1'b0);
            check8({tag, " reject"}, {7'b0, wr_reject}, {7'b0, v[4]});
            do_read(v[14:13], 1'b0);
            check8({tag, " R9 read"}, bus_rdata, v[12:5]);
            check8({tag, " reject drops"}, {7'b0, wr_reject}, 8'h00);
        end
        check8("R2 cnt port", cnt_q, 8'hFF);

        // R8 overflow event sets the flag
        @(negedge clk);
        ovf_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ovf_evt = 1'b0;
        do_read(2'd3, 1'b0);
        check8("R8 set", bus_rdata, 8'hBF);
        // R8 set and clear together: set wins
        do_write(2'd2, 1'b1, 16'hA500, 1'b1);
        do_read(2'd3, 1'b0);
        check8("R8 set beats clear", bus_rdata, 8'hBF);
        // R5 clear alone
        do_write(2'd2, 1'b1, 16'hA500, 1'b0);
        check8("R5 flag port", {7'b0, ovf_flag}, 8'h00);

        // R10 idle reads
        do_read(2'd2, 1'b0);
        check8("R10 offset 2 read", bus_rdata, 8'hFF);
        do_read(2'd1, 1'b1);
        check8("R10 word read", bus_rdata, 8'hFF);
        do_read(2'd1, 1'b0);
        check8("R10 count intact", bus_rdata, 8'hFF);

        // R11 back-to-back write then read, no idle cycle
        @(negedge clk);
        bus_off = 2'd0; bus_word = 1'b1; bus_wdata = 16'h5A12; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        do_read(2'd1, 1'b0);
        check8("R11 next-cycle read", bus_rdata, 8'h12);

        finish_run();
    end
endmodule